// File: doc/BRIEF.md
# Condition Code and Floating-Mode Loader

This block carries out two status-load instructions. Each one writes the 4-bit condition code and/or the four floating-point mode bits (round, significance, zero, normalize) kept in the processor status. The immediate variant takes its data from the low byte of the instruction word. The byte variant takes it from an operand byte that the memory side delivers later, through a byte-valid strobe. Two separate enable bits in the instruction word decide which of the two status groups is written.

An illegal immediate-form instruction raises a one-cycle trap request toward a fixed vector and leaves every status bit untouched. The illegal cases are an indirect reference or a set leading bit. The block sits beside the decode stage. It receives the instruction word, the indirect flag from address generation, and the fetched byte. It drives the status fields back to the rest of the core.

Bit numbering in the instruction follows a big-endian convention: instruction bit n is `instr_word[31-n]`, and byte bit n is `byte_data[7-n]`.

Top module: `psw_mode_loader`

## Requirements
- R1: A synchronous active-high reset clears `cc_q`, `fmode_q` and `trap_req` to 0 and discards any byte-form instruction that is waiting.
- R2: The opcode is instruction bits 1-7 (`instr_word[30:24]`), and the immediate form has opcode `OPC_IMM` (default 7'h02). A legal immediate form with bit 10 (`instr_word[21]`) set loads `cc_q` from instruction bits 24-27 (`instr_word[7:4]`), with bit 24 going to `cc_q[3]`. The new value is visible after the clock edge that samples `instr_valid`.
- R3: A legal immediate form with bit 11 (`instr_word[20]`) set loads `fmode_q` from instruction bits 28-31 (`instr_word[3:0]`). The order is round, significance, zero, normalize, with round in `fmode_q[3]`.
- R4: With bit 10 clear the condition code keeps its value, and with bit 11 clear the mode bits keep theirs. The two enables act independently.
- R5: The byte form has opcode `OPC_BYTE` (default 7'h70), and its enables are captured when `instr_valid` is high. On the first later cycle with `byte_valid` high, `byte_data[7:4]` (byte bits 0-3) goes to `cc_q` if bit 10 was set, and `byte_data[3:0]` (byte bits 4-7) goes to `fmode_q` if bit 11 was set. The byte form never traps, whatever the indirect flag or bit 0.
- R6: `byte_valid` has no effect when no byte form is waiting, and this includes the very cycle in which the byte-form instruction itself is presented.
- R7: An immediate form with `instr_indirect` high or bit 0 (`instr_word[31]`) set raises `trap_req` for the cycle after that edge and writes no status bit, even with bit 10 or bit 11 set. `trap_vector` reads 8'h40.
- R8: Any `instr_valid` cancels a waiting byte form. A `byte_valid` in that same cycle is ignored.
- R9: An instruction with any other opcode changes no status bit and raises no trap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is presented this cycle |
| instr_word | input | 32 | Instruction word, big-endian bit numbering |
| instr_indirect | input | 1 | Instruction is indirectly addressed |
| byte_valid | input | 1 | Operand byte is presented this cycle |
| byte_data | input | 8 | Operand byte for the byte form |
| cc_q | output | 4 | Condition code |
| fmode_q | output | 4 | Mode bits {round, significance, zero, normalize} |
| trap_req | output | 1 | One-cycle nonexistent-instruction trap request |
| trap_vector | output | 8 | Trap target location |

## Verification
The waiting state of the byte form cannot be seen directly at the ports. If it is wrong, the fault shows only when a byte arrives: a byte that should be dropped changes the status, or a byte that should land does not. The error therefore becomes visible one edge after that `byte_valid`, and may stay hidden for many cycles. Enable or field-slice errors show on `cc_q` or `fmode_q` one edge after the instruction. A trap decode error shows on `trap_req` in the same cycle as the status change that should not have happened. The reference model compares all four outputs on every cycle, so any of these faults is caught at its first visible cycle.

// File: rtl/psw_ldr_pkg.sv
package psw_ldr_pkg;

    localparam int WORD_W = 32;
    localparam int OPC_W  = 7;
    localparam int GRP_W  = 4;
    localparam int BYTE_W = 8;

    // big-endian bit n maps to little-endian index WORD_W-1-n
    localparam int BIT_LEAD = WORD_W - 1 - 0;
    localparam int BIT_CCEN = WORD_W - 1 - 10;
    localparam int BIT_FMEN = WORD_W - 1 - 11;
    localparam int OPC_HI   = WORD_W - 1 - 1;
    localparam int OPC_LO   = WORD_W - 1 - 7;

    typedef struct packed {
        logic [GRP_W-1:0] cc;
        logic [GRP_W-1:0] fm;
        logic             trap;
    } status_t;

    typedef struct packed {
        logic busy;
        logic cc_en;
        logic fm_en;
    } pend_t;

endpackage

// File: rtl/psw_ldr_decode.sv
module psw_ldr_decode
    import psw_ldr_pkg::*;
#(
    parameter logic [OPC_W-1:0] OPC_IMM  = 7'h02,
    parameter logic [OPC_W-1:0] OPC_BYTE = 7'h70
) (
    input  logic              valid_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              indirect_i,
    output logic              is_byte_o,
    output logic              fire_o,
    output logic              trap_o,
    output logic              cc_en_o,
    output logic              fm_en_o,
    output logic [GRP_W-1:0]  imm_cc_o,
    output logic [GRP_W-1:0]  imm_fm_o
);
    logic [OPC_W-1:0] opc;
    logic             is_imm;
    logic             illegal;
    logic             unused_fields;

    always_comb begin
        opc       = word_i[OPC_HI:OPC_LO];
        is_imm    = valid_i && (opc == OPC_IMM);
        is_byte_o = valid_i && (opc == OPC_BYTE);
        illegal   = indirect_i || word_i[BIT_LEAD];
        trap_o    = is_imm && illegal;
        fire_o    = is_imm && !illegal;
        cc_en_o   = word_i[BIT_CCEN];
        fm_en_o   = word_i[BIT_FMEN];
        imm_cc_o  = word_i[2*GRP_W-1:GRP_W];
        imm_fm_o  = word_i[GRP_W-1:0];
    end

    assign unused_fields = ^{word_i[OPC_LO-1:BIT_CCEN+1], word_i[BIT_FMEN-1:2*GRP_W]};

endmodule

// File: rtl/psw_ldr_pend.sv
module psw_ldr_pend
    import psw_ldr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic valid_i,
    input  logic is_byte_i,
    input  logic cc_en_i,
    input  logic fm_en_i,
    input  logic byte_valid_i,
    output logic commit_o,
    output logic cc_en_o,
    output logic fm_en_o
);
    pend_t pend_d, pend_q;

    always_comb begin
        pend_d   = pend_q;
        commit_o = 1'b0;
        if (valid_i) begin
            pend_d.busy  = is_byte_i;
            pend_d.cc_en = cc_en_i;
            pend_d.fm_en = fm_en_i;
        end else if (pend_q.busy && byte_valid_i) begin
            commit_o    = 1'b1;
            pend_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

    assign cc_en_o = pend_q.cc_en;
    assign fm_en_o = pend_q.fm_en;

    // a non-byte instruction leaves nothing waiting
    assert_cancel_R8: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !is_byte_i) |=> !pend_q.busy);

endmodule

// File: rtl/psw_ldr_state.sv
module psw_ldr_state
    import psw_ldr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire_i,
    input  logic              trap_i,
    input  logic              imm_cc_en_i,
    input  logic              imm_fm_en_i,
    input  logic [GRP_W-1:0]  imm_cc_i,
    input  logic [GRP_W-1:0]  imm_fm_i,
    input  logic              commit_i,
    input  logic              byte_cc_en_i,
    input  logic              byte_fm_en_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [GRP_W-1:0]  cc_o,
    output logic [GRP_W-1:0]  fm_o,
    output logic              trap_o
);
    status_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.trap = trap_i;
        if (fire_i) begin
            if (imm_cc_en_i) st_d.cc = imm_cc_i;
            if (imm_fm_en_i) st_d.fm = imm_fm_i;
        end else if (commit_i) begin
            if (byte_cc_en_i) st_d.cc = byte_i[BYTE_W-1:GRP_W];
            if (byte_fm_en_i) st_d.fm = byte_i[GRP_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cc_o   = st_q.cc;
    assign fm_o   = st_q.fm;
    assign trap_o = st_q.trap;

    assert_cc_hold_R4: assert property (@(posedge clk) disable iff (rst)
        ((!fire_i || !imm_cc_en_i) && (!commit_i || !byte_cc_en_i)) |=> $stable(st_q.cc));

    assert_fm_hold_R4: assert property (@(posedge clk) disable iff (rst)
        ((!fire_i || !imm_fm_en_i) && (!commit_i || !byte_fm_en_i)) |=> $stable(st_q.fm));

endmodule

// File: rtl/psw_mode_loader.sv
module psw_mode_loader
    import psw_ldr_pkg::*;
#(
    parameter logic [OPC_W-1:0] OPC_IMM   = 7'h02,
    parameter logic [OPC_W-1:0] OPC_BYTE  = 7'h70,
    parameter int               VEC_W     = 8,
    parameter logic [VEC_W-1:0] TRAP_VEC  = 8'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [WORD_W-1:0] instr_word,
    input  logic              instr_indirect,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    output logic [GRP_W-1:0]  cc_q,
    output logic [GRP_W-1:0]  fmode_q,
    output logic              trap_req,
    output logic [VEC_W-1:0]  trap_vector
);
    logic             is_byte, fire, trap_d;
    logic             cc_en, fm_en;
    logic [GRP_W-1:0] imm_cc, imm_fm;
    logic             commit, p_cc_en, p_fm_en;

    psw_ldr_decode #(.OPC_IMM(OPC_IMM), .OPC_BYTE(OPC_BYTE)) u_decode (
        .valid_i    (instr_valid),
        .word_i     (instr_word),
        .indirect_i (instr_indirect),
        .is_byte_o  (is_byte),
        .fire_o     (fire),
        .trap_o     (trap_d),
        .cc_en_o    (cc_en),
        .fm_en_o    (fm_en),
        .imm_cc_o   (imm_cc),
        .imm_fm_o   (imm_fm)
    );

    psw_ldr_pend u_pend (
        .clk          (clk),
        .rst          (rst),
        .valid_i      (instr_valid),
        .is_byte_i    (is_byte),
        .cc_en_i      (cc_en),
        .fm_en_i      (fm_en),
        .byte_valid_i (byte_valid),
        .commit_o     (commit),
        .cc_en_o      (p_cc_en),
        .fm_en_o      (p_fm_en)
    );

    psw_ldr_state u_state (
        .clk          (clk),
        .rst          (rst),
        .fire_i       (fire),
        .trap_i       (trap_d),
        .imm_cc_en_i  (cc_en),
        .imm_fm_en_i  (fm_en),
        .imm_cc_i     (imm_cc),
        .imm_fm_i     (imm_fm),
        .commit_i     (commit),
        .byte_cc_en_i (p_cc_en),
        .byte_fm_en_i (p_fm_en),
        .byte_i       (byte_data),
        .cc_o         (cc_q),
        .fm_o         (fmode_q),
        .trap_o       (trap_req)
    );

    assign trap_vector = TRAP_VEC;

    assert_trap_nowrite_R7: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> (cc_q == $past(cc_q) && fmode_q == $past(fmode_q)));

    assert_trap_cause_R7: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> $past(instr_valid));

    assert_idle_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (!instr_valid && !byte_valid) |=> ($stable(cc_q) && $stable(fmode_q)));

endmodule

// File: tb/psw_mode_loader_bench.sv
module psw_mode_loader_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [6:0] OP_IMM  = 7'h02;
    localparam logic [6:0] OP_BYTE = 7'h70;

    logic        clk = 1'b0;
    logic        rst;
    logic        instr_valid;
    logic [31:0] instr_word;
    logic        instr_indirect;
    logic        byte_valid;
    logic [7:0]  byte_data;
    logic [3:0]  cc_q, fmode_q;
    logic        trap_req;
    logic [7:0]  trap_vector;

    int checks = 0;
    int fails  = 0;

    // reference model state
    bit [3:0] m_cc, m_fm;
    bit       m_trap, m_busy, m_pcc, m_pfm;

    always #(CLK_PERIOD/2) clk = ~clk;

    psw_mode_loader u_psw_mode_loader (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
        .instr_indirect(instr_indirect), .byte_valid(byte_valid), .byte_data(byte_data),
        .cc_q(cc_q), .fmode_q(fmode_q), .trap_req(trap_req), .trap_vector(trap_vector)
    );

    function automatic logic [31:0] mk(bit lead, logic [6:0] op, bit e10, bit e11, logic [7:0] lo);
        return {lead, op, 2'b00, e10, e11, 12'h000, lo};
    endfunction

    task automatic model_edge();
        bit t = 1'b0;
        if (rst) begin
            m_cc = 0; m_fm = 0; m_busy = 0; m_pcc = 0; m_pfm = 0;
        end else if (instr_valid) begin
            if (instr_word[30:24] == OP_IMM) begin
                if (instr_indirect || instr_word[31]) t = 1'b1;
                else begin
                    if (instr_word[21]) m_cc = instr_word[7:4];
                    if (instr_word[20]) m_fm = instr_word[3:0];
                end
            end
            m_busy = (instr_word[30:24] == OP_BYTE);
            m_pcc  = instr_word[21];
            m_pfm  = instr_word[20];
        end else if (byte_valid && m_busy) begin
            if (m_pcc) m_cc = byte_data[7:4];
            if (m_pfm) m_fm = byte_data[3:0];
            m_busy = 0;
        end
        m_trap = rst ? 1'b0 : t;
    endtask

    task automatic check(string tag);
        checks++;
        if (cc_q !== m_cc || fmode_q !== m_fm || trap_req !== m_trap || trap_vector !== 8'h40) begin
            fails++;
            $display("FAIL %s: actual cc=%h fm=%h trap=%b vec=%h expected cc=%h fm=%h trap=%b vec=40",
                     tag, cc_q, fmode_q, trap_req, trap_vector, m_cc, m_fm, m_trap);
        end
    endtask

    task automatic step(bit r, bit iv, logic [31:0] w, bit ind, bit bv, logic [7:0] bd, string tag);
        rst = r; instr_valid = iv; instr_word = w; instr_indirect = ind;
        byte_valid = bv; byte_data = bd;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag);
    endtask

    task automatic idle(string tag);
        step(0, 0, 32'h0, 0, 0, 8'h00, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(1, 0, 32'h0, 0, 0, 8'h00, "R1");
        step(1, 0, 32'h0, 0, 0, 8'h00, "R1");
        // R2 condition code only
        step(0, 1, mk(0, OP_IMM, 1, 0, 8'hA5), 0, 0, 8'h00, "R2");
        // R3 mode bits only
        step(0, 1, mk(0, OP_IMM, 0, 1, 8'h3C), 0, 0, 8'h00, "R3");
        // R4 neither enable
        step(0, 1, mk(0, OP_IMM, 0, 0, 8'hFF), 0, 0, 8'h00, "R4");
        step(0, 1, mk(0, OP_IMM, 1, 1, 8'h69), 0, 0, 8'h00, "R2");
        // R5 byte form with a gap before the byte
        step(0, 1, mk(1, OP_BYTE, 1, 1, 8'h00), 1, 0, 8'h00, "R5");
        idle("R5");
        step(0, 0, 32'h0, 0, 1, 8'hC3, "R5");
        step(0, 0, 32'h0, 0, 1, 8'h11, "R6");
        // R6 byte in the same cycle as the byte instruction
        step(0, 1, mk(0, OP_BYTE, 1, 0, 8'h00), 0, 1, 8'h77, "R6");
        step(0, 0, 32'h0, 0, 1, 8'h5E, "R5");
        // R7 traps
        step(0, 1, mk(0, OP_IMM, 1, 1, 8'h00), 1, 0, 8'h00, "R7");
        step(0, 1, mk(1, OP_IMM, 1, 1, 8'hFF), 0, 0, 8'h00, "R7");
        idle("R7");
        // R8 cancel by a later instruction, and byte in same cycle
        step(0, 1, mk(0, OP_BYTE, 1, 1, 8'h00), 0, 0, 8'h00, "R8");
        step(0, 1, mk(0, 7'h15, 1, 1, 8'h00), 0, 1, 8'h99, "R8");
        step(0, 0, 32'h0, 0, 1, 8'hAB, "R8");
        // R9 foreign opcode
        step(0, 1, mk(1, 7'h33, 1, 1, 8'h12), 1, 0, 8'h00, "R9");
        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            int sel = $urandom_range(0, 3);
            logic [6:0] op = (sel == 0) ? OP_IMM : (sel == 1) ? OP_BYTE : 7'($urandom);
            step(0, ($urandom_range(0, 2) == 0), mk(($urandom_range(0, 3) == 0), op,
                 1'($urandom), 1'($urandom), 8'($urandom)),
                 ($urandom_range(0, 3) == 0), 1'($urandom), 8'($urandom), "R5");
        end
        step(1, 0, 32'h0, 0, 0, 8'h00, "R1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule